// File: doc/BRIEF.md
# Banked Register AND Execute Unit

This unit executes one data-memory AND instruction for a small processor core. It holds the working register, the bank select register, the negative and zero flags and a banked data RAM. Instruction words arrive on a valid/ready stream. Each accepted word passes through four internal phases, one clock each: decode, operand read, process, write-back. The unit ANDs the working register with the addressed byte. It writes the result to the working register or back to the byte, and updates N and Z.

The address comes from an 8-bit file field and an access-select bit. With access-select set, the bank register supplies the upper address bits. With it clear, low file offsets go to bank 0 and high offsets go to the top bank. Words that do not carry the AND opcode still use four phases but change nothing. A plain setup port loads the working register, the bank register or a RAM byte while the unit is idle. A combinational peek port reads any RAM byte.

Back-pressure rules: `in_ready` is high in the idle phase and in the write-back phase. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. The producer holds `in_word` steady with `in_valid` until that edge. Dropping `in_valid` without a transfer is allowed and has no effect.

Top module: `andx_unit`

## Requirements
- R1: `in_ready` is high only in the idle and write-back phases. After a transfer it is low for the next three cycles. Words that are offered continuously transfer exactly every 4 cycles.
- R2: A word executes only when bits [15:10] equal 6'b000101. Any other word leaves the working register, bank register, flags and RAM unchanged, and never raises `retire`.
- R3: With bit 9 (d) at 0, the result goes to the working register and the RAM byte is unchanged.
- R4: With bit 9 (d) at 1, the result goes to the addressed RAM byte and the working register is unchanged.
- R5: With bit 8 (a) at 1, the RAM address is {bank register, bits [7:0]}.
- R6: With bit 8 (a) at 0, a file field of 0x00–0x7F addresses bank 0. A file field of 0x80–0xFF addresses the top bank (all bank bits 1). The bank register is ignored.
- R7: Each executed AND sets N to bit 7 of the result and Z to (result == 0). This holds for both destinations.
- R8: The results of a word transferred at edge k are visible on the ports after edge k+4. `retire` is high for exactly that one cycle.
- R9: The setup port `ld_sel` selects 0 = working register, 1 = bank register (low bits of `ld_data`), 2 = RAM byte at `ld_addr`, 3 = nothing. A load takes effect only when `ld_en` is high in the idle phase. Loads in any other phase are ignored.
- R10: After reset the working register, bank register, N, Z and `retire` are 0, and `in_ready` is 1.
- R11: With the working register at 0x17, the byte at 0xC2 and d = 0, the working register becomes 0x02 and the byte stays 0xC2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_word | input | 16 | Instruction word |
| in_ready | output | 1 | Unit can take a word this cycle |
| ld_en | input | 1 | Setup load strobe |
| ld_sel | input | 2 | Setup target select |
| ld_addr | input | BANK_BITS+8 | Setup RAM address |
| ld_data | input | 8 | Setup data |
| peek_addr | input | BANK_BITS+8 | RAM observe address |
| peek_data | output | 8 | RAM byte at `peek_addr` |
| wreg_o | output | 8 | Working register |
| bsr_o | output | BANK_BITS | Bank select register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| retire | output | 1 | One-cycle pulse after an AND completes |

## Verification
A wrong bank choice in the address path shows up after four cycles: the wrong RAM byte is read or written, and a peek at the intended byte disagrees with the model. A stuck phase register shows up within one cycle as a wrong `in_ready` value. A decode error that lets a foreign word execute shows up at write-back, as a spurious `retire` pulse and a changed register. Since the model is compared every clock, errors in flags or destination choice are caught in the cycle right after the bad write-back.

// File: rtl/andx_pkg.sv
package andx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DEC  = 3'd1,
    PH_RD   = 3'd2,
    PH_PROC = 3'd3,
    PH_WR   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    LD_WREG = 2'd0,
    LD_BANK = 2'd1,
    LD_MEM  = 2'd2,
    LD_NONE = 2'd3
  } ld_sel_e;

  localparam logic [5:0] OPC_ANDF = 6'b000101;
  localparam int DEST_BIT = 9;
  localparam int ACC_BIT  = 8;
  localparam int FILE_W   = 8;
endpackage

// File: rtl/andx_seq.sv
module andx_seq
  import andx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  output phase_e ph
);
  logic take;

  assign in_ready = (ph == PH_IDLE) || (ph == PH_WR);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
    end else if (take) begin
      ph <= PH_DEC;
    end else begin
      unique case (ph)
        PH_DEC:  ph <= PH_RD;
        PH_RD:   ph <= PH_PROC;
        PH_PROC: ph <= PH_WR;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R1: a transfer is followed by busy cycles
  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);
endmodule

// File: rtl/andx_decode.sv
module andx_decode
  import andx_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int AW = BANK_BITS + FILE_W
) (
  input  logic [15:0]          word,
  input  logic [BANK_BITS-1:0] bank_sel,
  output logic                 hit,
  output logic                 to_file,
  output logic [AW-1:0]        addr
);
  logic [FILE_W-1:0]    fsel;
  logic [BANK_BITS-1:0] bank;

  assign fsel    = word[FILE_W-1:0];
  assign hit     = (word[15:10] == OPC_ANDF);
  assign to_file = word[DEST_BIT];

  always_comb begin
    if (word[ACC_BIT]) bank = bank_sel;
    else               bank = {BANK_BITS{fsel[FILE_W-1]}};
    addr = {bank, fsel};
  end

  always_comb begin
    if (!word[ACC_BIT]) begin
      a_r6_access_bank: assert (addr[AW-1:FILE_W] == {BANK_BITS{word[FILE_W-1]}});
    end
  end
endmodule

// File: rtl/andx_dmem.sv
module andx_dmem #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  assign peek_data = mem[peek_addr];
endmodule

// File: rtl/andx_unit.sv
module andx_unit
  import andx_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int AW = BANK_BITS + FILE_W,
  localparam int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [15:0]          in_word,
  output logic                 in_ready,
  input  logic                 ld_en,
  input  logic [1:0]           ld_sel,
  input  logic [AW-1:0]        ld_addr,
  input  logic [DW-1:0]        ld_data,
  input  logic [AW-1:0]        peek_addr,
  output logic [DW-1:0]        peek_data,
  output logic [DW-1:0]        wreg_o,
  output logic [BANK_BITS-1:0] bsr_o,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 retire
);
  phase_e               ph;
  logic                 take, idle, ld_ok;
  logic [15:0]          instr_q;
  logic                 dec_hit, dec_file;
  logic [AW-1:0]        dec_addr;
  logic                 hit_q, file_q;
  logic [AW-1:0]        addr_q;
  logic [DW-1:0]        res_q, rd_data;
  logic [DW-1:0]        wreg_q;
  logic [BANK_BITS-1:0] bsr_q;
  logic                 n_q, z_q, retire_q;
  logic                 wb_mem, mem_we;
  logic [AW-1:0]        mem_waddr;
  logic [DW-1:0]        mem_wdata;

  andx_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .ph       (ph)
  );

  andx_decode #(.BANK_BITS(BANK_BITS)) u_dec (
    .word     (instr_q),
    .bank_sel (bsr_q),
    .hit      (dec_hit),
    .to_file  (dec_file),
    .addr     (dec_addr)
  );

  assign take   = in_valid && in_ready;
  assign idle   = (ph == PH_IDLE);
  assign ld_ok  = ld_en && idle;
  assign wb_mem = (ph == PH_WR) && hit_q && file_q;
  assign mem_we = wb_mem || (ld_ok && (ld_sel == LD_MEM));

  always_comb begin
    if (wb_mem) begin
      mem_waddr = addr_q;
      mem_wdata = res_q;
    end else begin
      mem_waddr = ld_addr;
      mem_wdata = ld_data;
    end
  end

  andx_dmem #(.AW(AW), .DW(DW)) u_mem (
    .clk       (clk),
    .we        (mem_we),
    .waddr     (mem_waddr),
    .wdata     (mem_wdata),
    .re        (ph == PH_RD),
    .raddr     (addr_q),
    .rdata     (rd_data),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instr_q  <= '0;
      hit_q    <= 1'b0;
      file_q   <= 1'b0;
      addr_q   <= '0;
      res_q    <= '0;
      wreg_q   <= '0;
      bsr_q    <= '0;
      n_q      <= 1'b0;
      z_q      <= 1'b0;
      retire_q <= 1'b0;
    end else begin
      if (take) instr_q <= in_word;
      if (ph == PH_DEC) begin
        hit_q  <= dec_hit;
        file_q <= dec_file;
        addr_q <= dec_addr;
      end
      if (ph == PH_PROC) res_q <= wreg_q & rd_data;
      retire_q <= (ph == PH_WR) && hit_q;
      if ((ph == PH_WR) && hit_q) begin
        if (!file_q) wreg_q <= res_q;
        n_q <= res_q[DW-1];
        z_q <= (res_q == '0);
      end
      if (ld_ok) begin
        unique case (ld_sel)
          LD_WREG: wreg_q <= ld_data;
          LD_BANK: bsr_q  <= ld_data[BANK_BITS-1:0];
          default: ;
        endcase
      end
    end
  end

  assign wreg_o = wreg_q;
  assign bsr_o  = bsr_q;
  assign flag_n = n_q;
  assign flag_z = z_q;
  assign retire = retire_q;

  a_r2_foreign_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_WR) && !hit_q) |=> !retire_q);

  a_r4_file_keeps_wreg: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_WR) && hit_q && file_q) |=> $stable(wreg_q));

  a_r7_flags_follow_wreg: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_q && !file_q) |-> ((z_q == (wreg_q == '0)) && (n_q == wreg_q[DW-1])));

  a_r8_retire_single: assert property (@(posedge clk) disable iff (!rst_n)
    retire_q |=> !retire_q);

  a_r9_busy_bank_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !idle && (ld_sel == LD_BANK)) |=> $stable(bsr_q));

  a_r9_busy_wreg_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && (ph == PH_DEC) && (ld_sel == LD_WREG)) |=> $stable(wreg_q));
endmodule

// File: tb/andx_unit_tb.sv
module andx_unit_tb;
  localparam int BB = 2;
  localparam int AW = BB + 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   in_word = '0;
  logic          in_ready;
  logic          ld_en = 1'b0;
  logic [1:0]    ld_sel = 2'd3;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [7:0]    peek_data;
  logic [7:0]    wreg_o;
  logic [BB-1:0] bsr_o;
  logic          flag_n, flag_z, retire;

  always #2.5 clk = ~clk;

  andx_unit #(.BANK_BITS(BB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .wreg_o(wreg_o), .bsr_o(bsr_o), .flag_n(flag_n), .flag_z(flag_z),
    .retire(retire)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit mem_init = 1'b0;
  int last_take = 0;

  // behavioural reference
  logic [7:0]    mem_m [DEPTH];
  logic [7:0]    wreg_m;
  logic [BB-1:0] bsr_m;
  logic          n_m, z_m, ret_m;
  int            ph_m;
  logic [15:0]   ins_m;

  function automatic logic [AW-1:0] ea(input logic [15:0] w, input logic [BB-1:0] b);
    logic [7:0] f;
    f = w[7:0];
    if (w[8]) return {b, f};
    if (f >= 8'h80) return {{BB{1'b1}}, f};
    return {{BB{1'b0}}, f};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      wreg_m = 0; bsr_m = 0; n_m = 0; z_m = 0; ret_m = 0; ph_m = 0; ins_m = 0;
    end else begin
      bit acc;
      acc = in_valid && (ph_m == 0 || ph_m == 4);
      ret_m = 0;
      if (ph_m == 0 && ld_en) begin
        if (ld_sel == 2'd0) wreg_m = ld_data;
        else if (ld_sel == 2'd1) bsr_m = ld_data[BB-1:0];
        else if (ld_sel == 2'd2) mem_m[ld_addr] = ld_data;
      end
      if (ph_m == 4 && ins_m[15:10] == 6'b000101) begin
        logic [AW-1:0] a;
        logic [7:0] r;
        a = ea(ins_m, bsr_m);
        r = wreg_m & mem_m[a];
        if (ins_m[9]) mem_m[a] = r; else wreg_m = r;
        n_m = r[7];
        z_m = (r == 0);
        ret_m = 1;
      end
      if (acc) begin ins_m = in_word; ph_m = 1; last_take = cyc; end
      else if (ph_m == 4) ph_m = 0;
      else if (ph_m != 0) ph_m++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", "in_ready", int'(in_ready), int'(ph_m == 0 || ph_m == 4));
      chk("R8", "retire", int'(retire), int'(ret_m));
      chk("R3", "wreg", int'(wreg_o), int'(wreg_m));
      chk("R9", "bank", int'(bsr_o), int'(bsr_m));
      chk("R7", "flag_n", int'(flag_n), int'(n_m));
      chk("R7", "flag_z", int'(flag_z), int'(z_m));
      if (mem_init) chk("R4", "peek", int'(peek_data), int'(mem_m[peek_addr]));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [1:0] s, input logic [AW-1:0] a, input logic [7:0] d);
    ld_en = 1; ld_sel = s; ld_addr = a; ld_data = d;
    tick();
    ld_en = 0; ld_sel = 2'd3;
  endtask

  task automatic send(input logic [15:0] w);
    bit ok;
    in_valid = 1; in_word = w;
    do begin
      ok = in_ready;
      tick();
    end while (!ok);
    in_valid = 0;
  endtask

  task automatic settle();
    repeat (5) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0, t1;
    repeat (4) tick();
    rst_n = 1;
    tick();
    // R10 reset state
    chk("R10", "reset wreg", int'(wreg_o), 0);
    chk("R10", "reset bank", int'(bsr_o), 0);
    chk("R10", "reset flags", int'({flag_n, flag_z}), 0);
    chk("R10", "reset ready", int'(in_ready), 1);
    chk("R10", "reset retire", int'(retire), 0);

    for (int a = 0; a < DEPTH; a++) load(2'd2, AW'(a), 8'((a * 37 + 11) & 255));
    mem_init = 1;

    // R11 worked example, access bank low half
    load(2'd0, '0, 8'h17);
    load(2'd2, AW'(10'h005), 8'hC2);
    send(16'h1405);
    settle();
    chk("R11", "wreg", int'(wreg_o), 8'h02);
    peek_addr = AW'(10'h005); #1;
    chk("R11", "file kept", int'(peek_data), 8'hC2);
    chk("R3", "N/Z", int'({flag_n, flag_z}), 0);

    // R4/R5 banked, result to file
    load(2'd0, '0, 8'hF0);
    load(2'd1, '0, 8'h02);
    load(2'd2, AW'(10'h23C), 8'h3C);
    send(16'h173C);
    settle();
    peek_addr = AW'(10'h23C); #1;
    chk("R5", "banked file", int'(peek_data), 8'h30);
    chk("R4", "wreg kept", int'(wreg_o), 8'hF0);

    // R6 access bank high half -> top bank, N set
    load(2'd0, '0, 8'hFF);
    load(2'd2, AW'(10'h3A0), 8'h80);
    send(16'h14A0);
    settle();
    chk("R6", "top bank", int'(wreg_o), 8'h80);
    chk("R7", "N set", int'(flag_n), 1);

    // R6 access bank low half ignores bank register, Z set
    load(2'd0, '0, 8'hF0);
    load(2'd2, AW'(10'h010), 8'h0F);
    send(16'h1410);
    settle();
    chk("R6", "bank0", int'(wreg_o), 0);
    chk("R7", "Z set", int'(flag_z), 1);

    // R2 foreign opcode
    send(16'h1C10);
    settle();
    chk("R2", "foreign wreg", int'(wreg_o), 0);

    // R1 back-to-back spacing
    send(16'h1410); t0 = last_take;
    send(16'h1611); t1 = last_take;
    chk("R1", "spacing", t1 - t0, 4);
    settle();

    // R9 load during busy ignored
    send(16'h1410);
    load(2'd0, '0, 8'h5A);
    settle();
    chk("R9", "busy load", int'(wreg_o), int'(wreg_m));

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[15:10] = 6'b000101;
      peek_addr = AW'($urandom);
      send(w);
      if ($urandom % 3 == 0) begin
        ld_en = 1; ld_sel = 2'($urandom); ld_addr = AW'($urandom); ld_data = 8'($urandom);
        tick(); tick();
        ld_en = 0; ld_sel = 2'd3;
      end
      if ($urandom % 2 == 0) begin
        peek_addr = ea(w, bsr_m);
        settle();
        load(2'($urandom % 3), AW'($urandom), 8'($urandom));
      end
    end
    settle();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule